// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small bank of ownership tokens that two agents, a left side and a right side, use to agree on who may touch a shared resource. The bank sits apart from any data storage. Each side selects one token by a low-order index inside its address, writes a single bit to ask for or give up the token, and reads back whether it now holds it. A read tells the reader only one thing: 0 means "this side owns the token", 1 means "it does not".

Each token keeps a request flag per side, so a request made while the other side holds the token is not lost. It waits, and the moment the holder gives the token up, the waiting side holds it with no further action. When both sides ask for a free token in the same clock cycle, the left side wins and the right side's request waits.

Reads go through a per-side result register. The result shows up one cycle after the read strobe with a one-cycle valid pulse and then stays put until that side reads again. The read interface has no back-pressure. A result cannot be refused, and a new read overwrites the register.

Top module: `two_port_sema_bank`

## Requirements
- R1: A synchronous reset makes every token free, clears every pending request, drives both valid outputs low and loads both read registers with all ones.
- R2: The token is chosen by the lowest IDX_W address bits (8 tokens for IDX_W = 3). The remaining address bits have no effect on which token is read or written.
- R3: A write uses only bit 0 of the write data: 0 requests the token, 1 releases it or withdraws a pending request. All other data bits are ignored.
- R4: A request on a free token makes the requester the owner at once. The owner then reads 0 and the other side reads 1.
- R5: A request from the side that does not own the token is refused. Ownership stays where it was, and the refused request remains pending.
- R6: When the owner writes 1 and the other side has a request pending, the other side becomes owner on the same clock edge.
- R7: When the owner writes 1 and the other side has no pending request, the token becomes free and both sides read 1.
- R8: A side that does not own a token and writes 1 to it withdraws its pending request. A later release by the owner then leaves the token free.
- R9: When both sides request the same free token in one cycle, exactly one side, the left, becomes owner, and the right request stays pending.
- R10: A read (select high, write strobe low) raises that side's valid output in the next cycle, with the read value copied onto every data bit. Without a read, valid is low and the read data holds its last value.
- R11: A read returns the token state as it was before the clock edge that captures it. A write by the other side on that same edge does not change the captured value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| l_sel | input | 1 | Left side: token access strobe |
| l_we | input | 1 | Left side: 1 = write, 0 = read |
| l_addr | input | ADDR_W | Left side: address, low IDX_W bits pick the token |
| l_wdata | input | DATA_W | Left side: write data, bit 0 used |
| l_rvalid | output | 1 | Left side: read result valid (one-cycle pulse) |
| l_rdata | output | DATA_W | Left side: registered read result, all bits equal |
| r_sel | input | 1 | Right side: token access strobe |
| r_we | input | 1 | Right side: 1 = write, 0 = read |
| r_addr | input | ADDR_W | Right side: address, low IDX_W bits pick the token |
| r_wdata | input | DATA_W | Right side: write data, bit 0 used |
| r_rvalid | output | 1 | Right side: read result valid (one-cycle pulse) |
| r_rdata | output | DATA_W | Right side: registered read result, all bits equal |

## Verification
Ownership state is visible at the ports only through reads, so a wrong owner or a lost pending request appears on the first read of that token after the faulty edge: one cycle after the read strobe, as a 0 or 1 of the wrong sense on all data bits. A request that is dropped instead of kept pending stays hidden until the owner releases. It then shows up as a 1 where the waiting side expects 0, so the checks read both sides right after every release. Both sides owning the same token at once is caught whenever the two sides read that index in the same cycle and both see 0.

// File: rtl/sema_pkg.sv
package sema_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  typedef struct packed {
    logic wr;
    logic val;
  } wr_req_t;
endpackage

// File: rtl/sema_port_dec.sv
module sema_port_dec #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 9,
  parameter int IDX_W  = 3,
  localparam int NUM   = 1 << IDX_W
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM-1:0]    wr_hit,
  output logic              wr_val,
  output logic              rd_req,
  output logic [IDX_W-1:0]  rd_idx
);
  logic [IDX_W-1:0] idx;
  assign idx    = addr[IDX_W-1:0];
  assign wr_val = wdata[0];
  assign rd_req = sel && !we;
  assign rd_idx = idx;

  generate
    for (genvar g = 0; g < NUM; g++) begin : g_hit
      assign wr_hit[g] = sel && we && (idx == IDX_W'(g));
    end
    if (ADDR_W > IDX_W) begin : g_addr_hi
      logic unused_addr_hi;
      assign unused_addr_hi = ^addr[ADDR_W-1:IDX_W];
    end
    if (DATA_W > 1) begin : g_data_hi
      logic unused_data_hi;
      assign unused_data_hi = ^wdata[DATA_W-1:1];
    end
  endgenerate
endmodule

// File: rtl/sema_cell.sv
module sema_cell
  import sema_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_l,
  input  logic val_l,
  input  logic wr_r,
  input  logic val_r,
  output logic own_l,
  output logic own_r,
  output logic req_l,
  output logic req_r
);
  owner_e owner_q, owner_nx;
  logic   req_l_q, req_r_q, req_l_nx, req_r_nx;

  // a write of 0 raises the side's request, a write of 1 drops it
  assign req_l_nx = wr_l ? ~val_l : req_l_q;
  assign req_r_nx = wr_r ? ~val_r : req_r_q;

  always_comb begin
    owner_nx = owner_q;
    unique case (owner_q)
      OWN_LEFT: begin
        if (!req_l_nx) owner_nx = req_r_nx ? OWN_RIGHT : OWN_NONE;
      end
      OWN_RIGHT: begin
        if (!req_r_nx) owner_nx = req_l_nx ? OWN_LEFT : OWN_NONE;
      end
      default: begin
        if (req_l_nx)      owner_nx = OWN_LEFT;
        else if (req_r_nx) owner_nx = OWN_RIGHT;
        else               owner_nx = OWN_NONE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= OWN_NONE;
      req_l_q <= 1'b0;
      req_r_q <= 1'b0;
    end else begin
      owner_q <= owner_nx;
      req_l_q <= req_l_nx;
      req_r_q <= req_r_nx;
    end
  end

  assign own_l = (owner_q == OWN_LEFT);
  assign own_r = (owner_q == OWN_RIGHT);
  assign req_l = req_l_q;
  assign req_r = req_r_q;
endmodule

// File: rtl/sema_rd_reg.sv
module sema_rd_reg #(
  parameter int DATA_W = 9,
  parameter int IDX_W  = 3,
  localparam int NUM   = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [NUM-1:0]    own_mine,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '1;
    end else begin
      rvalid <= rd_req;
      if (rd_req) rdata <= {DATA_W{~own_mine[rd_idx]}};
    end
  end
endmodule

// File: rtl/two_port_sema_bank.sv
module two_port_sema_bank #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 9,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sel,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic              l_rvalid,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic              r_rvalid,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int NUM = 1 << IDX_W;

  logic [NUM-1:0]   hit_l, hit_r;
  logic             val_l, val_r;
  logic             rd_l, rd_r;
  logic [IDX_W-1:0] ridx_l, ridx_r;
  logic [NUM-1:0]   own_l_v, own_r_v, req_l_v, req_r_v;

  sema_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec_l (
    .sel(l_sel), .we(l_we), .addr(l_addr), .wdata(l_wdata),
    .wr_hit(hit_l), .wr_val(val_l), .rd_req(rd_l), .rd_idx(ridx_l)
  );

  sema_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec_r (
    .sel(r_sel), .we(r_we), .addr(r_addr), .wdata(r_wdata),
    .wr_hit(hit_r), .wr_val(val_r), .rd_req(rd_r), .rd_idx(ridx_r)
  );

  generate
    for (genvar g = 0; g < NUM; g++) begin : g_cell
      sema_cell u_cell (
        .clk(clk), .rst(rst),
        .wr_l(hit_l[g]), .val_l(val_l),
        .wr_r(hit_r[g]), .val_r(val_r),
        .own_l(own_l_v[g]), .own_r(own_r_v[g]),
        .req_l(req_l_v[g]), .req_r(req_r_v[g])
      );
    end
  endgenerate

  sema_rd_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd_l (
    .clk(clk), .rst(rst), .rd_req(rd_l), .rd_idx(ridx_l),
    .own_mine(own_l_v), .rvalid(l_rvalid), .rdata(l_rdata)
  );

  sema_rd_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd_r (
    .clk(clk), .rst(rst), .rd_req(rd_r), .rd_idx(ridx_r),
    .own_mine(own_r_v), .rvalid(r_rvalid), .rdata(r_rdata)
  );
endmodule

// File: rtl/sema_bank_chk.sv
module sema_bank_chk #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 9,
  parameter int IDX_W  = 3,
  localparam int NUM   = 1 << IDX_W
) (
  input logic              clk,
  input logic              rst,
  input logic              l_sel,
  input logic              l_we,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_wdata,
  input logic              l_rvalid,
  input logic [DATA_W-1:0] l_rdata,
  input logic              r_sel,
  input logic              r_we,
  input logic [ADDR_W-1:0] r_addr,
  input logic [DATA_W-1:0] r_wdata,
  input logic              r_rvalid,
  input logic [DATA_W-1:0] r_rdata,
  input logic [NUM-1:0]    own_l_v,
  input logic [NUM-1:0]    own_r_v,
  input logic [NUM-1:0]    req_r_v
);
  assert_reset_frees_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (l_rdata == '1 && r_rdata == '1 && !l_rvalid && !r_rvalid));

  assert_l_valid_after_read_R10: assert property (@(posedge clk) disable iff (rst)
    (l_sel && !l_we) |=> l_rvalid);
  assert_r_valid_after_read_R10: assert property (@(posedge clk) disable iff (rst)
    (r_sel && !r_we) |=> r_rvalid);
  assert_l_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (rst)
    !(l_sel && !l_we) |=> !l_rvalid);
  assert_l_rdata_uniform_R10: assert property (@(posedge clk) disable iff (rst)
    (l_rdata == '0 || l_rdata == '1));
  assert_r_rdata_held_R10: assert property (@(posedge clk) disable iff (rst)
    !r_rvalid |-> $stable(r_rdata));

  assert_no_double_owner_R9: assert property (@(posedge clk) disable iff (rst)
    (l_rvalid && r_rvalid &&
     $past(l_addr[IDX_W-1:0]) == $past(r_addr[IDX_W-1:0])) |-> (l_rdata[0] || r_rdata[0]));

  generate
    for (genvar g = 0; g < NUM; g++) begin : g_tok
      logic l_rel, r_rel;
      assign l_rel = l_sel && l_we && l_addr[IDX_W-1:0] == IDX_W'(g) && l_wdata[0];
      assign r_rel = r_sel && r_we && r_addr[IDX_W-1:0] == IDX_W'(g) && r_wdata[0];

      assert_owner_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (own_l_v[g] && !l_rel) |=> own_l_v[g]);

      assert_release_hands_over_R6: assert property (@(posedge clk) disable iff (rst)
        (own_l_v[g] && l_rel && req_r_v[g] && !r_rel) |=> own_r_v[g]);
    end
  endgenerate
endmodule

bind two_port_sema_bank sema_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst),
  .l_sel(l_sel), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
  .l_rvalid(l_rvalid), .l_rdata(l_rdata),
  .r_sel(r_sel), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
  .r_rvalid(r_rvalid), .r_rdata(r_rdata),
  .own_l_v(own_l_v), .own_r_v(own_r_v), .req_r_v(req_r_v)
);

// File: tb/tb_two_port_sema_bank.sv
module tb_two_port_sema_bank;
  localparam int ADDR_W = 14;
  localparam int DATA_W = 9;
  localparam int IDX_W  = 3;
  localparam int NUM    = 1 << IDX_W;
  localparam int OP_IDLE = 0, OP_WR = 1, OP_RD = 2;

  logic clk = 1'b0;
  logic rst;
  logic l_sel, l_we, r_sel, r_we;
  logic [ADDR_W-1:0] l_addr, r_addr;
  logic [DATA_W-1:0] l_wdata, r_wdata;
  logic l_rvalid, r_rvalid;
  logic [DATA_W-1:0] l_rdata, r_rdata;

  always #2 clk = ~clk;

  two_port_sema_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rvalid(l_rvalid), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rvalid(r_rvalid), .r_rdata(r_rdata)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  // bench model: 0 free, 1 left, 2 right
  int own_m [NUM];
  bit pl_m [NUM];
  bit pr_m [NUM];
  logic [DATA_W-1:0] last_l, last_r, got_l, got_r;
  logic [ADDR_W-1:0] hi_l, hi_r;
  logic [DATA_W-1:0] dhi_l, dhi_r;

  task automatic chk(input string tag, input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NUM; i++) begin
      own_m[i] = 0; pl_m[i] = 0; pr_m[i] = 0;
    end
    last_l = '1; last_r = '1;
  endtask

  // one clock of stimulus on both sides; called at a falling edge
  task automatic cyc(input string tag,
                     input int lop, input int li, input bit lv,
                     input int rop, input int ri, input bit rv);
    logic [DATA_W-1:0] exp_l, exp_r;
    l_sel = (lop != OP_IDLE); l_we = (lop == OP_WR);
    r_sel = (rop != OP_IDLE); r_we = (rop == OP_WR);
    l_addr = (hi_l << IDX_W) | ADDR_W'(li);
    r_addr = (hi_r << IDX_W) | ADDR_W'(ri);
    l_wdata = (dhi_l << 1) | DATA_W'(lv);
    r_wdata = (dhi_r << 1) | DATA_W'(rv);
    exp_l = (own_m[li] == 1) ? '0 : '1;
    exp_r = (own_m[ri] == 2) ? '0 : '1;
    if (lop == OP_WR) pl_m[li] = ~lv;
    if (rop == OP_WR) pr_m[ri] = ~rv;
    for (int i = 0; i < NUM; i++) begin
      if (own_m[i] == 1) begin
        if (!pl_m[i]) own_m[i] = pr_m[i] ? 2 : 0;
      end else if (own_m[i] == 2) begin
        if (!pr_m[i]) own_m[i] = pl_m[i] ? 1 : 0;
      end else begin
        own_m[i] = pl_m[i] ? 1 : (pr_m[i] ? 2 : 0);
      end
    end
    @(negedge clk);
    got_l = l_rdata; got_r = r_rdata;
    if (lop == OP_RD) begin
      chk({tag, " R10 l_rvalid"}, DATA_W'(l_rvalid), DATA_W'(1));
      chk({tag, " l_rdata"}, l_rdata, exp_l);
      last_l = exp_l;
    end else begin
      chk({tag, " R10 l_rvalid low"}, DATA_W'(l_rvalid), DATA_W'(0));
      chk({tag, " R10 l_rdata held"}, l_rdata, last_l);
    end
    if (rop == OP_RD) begin
      chk({tag, " R10 r_rvalid"}, DATA_W'(r_rvalid), DATA_W'(1));
      chk({tag, " r_rdata"}, r_rdata, exp_r);
      last_r = exp_r;
    end else begin
      chk({tag, " R10 r_rvalid low"}, DATA_W'(r_rvalid), DATA_W'(0));
      chk({tag, " R10 r_rdata held"}, r_rdata, last_r);
    end
  endtask

  task automatic rd_both(input string tag, input int idx, input bit el, input bit er);
    cyc(tag, OP_RD, idx, 1'b0, OP_RD, idx, 1'b0);
    chk({tag, " left literal"}, got_l, {DATA_W{el}});
    chk({tag, " right literal"}, got_r, {DATA_W{er}});
  endtask

  task automatic do_reset();
    rst = 1'b1;
    l_sel = 0; l_we = 0; r_sel = 0; r_we = 0;
    repeat (2) @(negedge clk);
    model_reset();
    chk("R1 l_rvalid", DATA_W'(l_rvalid), DATA_W'(0));
    chk("R1 l_rdata", l_rdata, '1);
    chk("R1 r_rdata", r_rdata, '1);
    rst = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    hi_l = '0; hi_r = '0; dhi_l = '0; dhi_r = '0;
    l_addr = '0; r_addr = '0; l_wdata = '0; r_wdata = '0;
    @(negedge clk);
    do_reset();

    for (int i = 0; i < NUM; i++) rd_both("R1 free after reset", i, 1'b1, 1'b1);

    // R4: request a free token
    cyc("R4 req", OP_WR, 2, 1'b0, OP_IDLE, 0, 1'b0);
    rd_both("R4 owner reads 0", 2, 1'b0, 1'b1);
    // R5: refused request; owner rewriting 0 changes nothing
    cyc("R5 req denied", OP_IDLE, 0, 1'b0, OP_WR, 2, 1'b0);
    cyc("R5 owner rewrites", OP_WR, 2, 1'b0, OP_IDLE, 0, 1'b0);
    rd_both("R5 ownership kept", 2, 1'b0, 1'b1);
    // R6: release hands over to pending side
    cyc("R6 release", OP_WR, 2, 1'b1, OP_IDLE, 0, 1'b0);
    rd_both("R6 handed over", 2, 1'b1, 1'b0);
    // R8: pending left request withdrawn, then right releases
    cyc("R8 left asks", OP_WR, 2, 1'b0, OP_IDLE, 0, 1'b0);
    cyc("R8 left withdraws", OP_WR, 2, 1'b1, OP_IDLE, 0, 1'b0);
    cyc("R8 right releases", OP_IDLE, 0, 1'b0, OP_WR, 2, 1'b1);
    rd_both("R8 token free", 2, 1'b1, 1'b1);
    // R7: release without pending request
    cyc("R7 req", OP_IDLE, 0, 1'b0, OP_WR, 5, 1'b0);
    rd_both("R7 right owns", 5, 1'b1, 1'b0);
    cyc("R7 release", OP_IDLE, 0, 1'b0, OP_WR, 5, 1'b1);
    rd_both("R7 both read 1", 5, 1'b1, 1'b1);
    // R9: same-cycle tie on a free token
    cyc("R9 tie", OP_WR, 6, 1'b0, OP_WR, 6, 1'b0);
    rd_both("R9 left wins", 6, 1'b0, 1'b1);
    cyc("R9 left release", OP_WR, 6, 1'b1, OP_IDLE, 0, 1'b0);
    rd_both("R9 right pending granted", 6, 1'b1, 1'b0);
    cyc("R9 cleanup", OP_IDLE, 0, 1'b0, OP_WR, 6, 1'b1);
    // R2: upper address bits ignored
    hi_l = 11'h5A5;
    cyc("R2 req via aliased addr", OP_WR, 1, 1'b0, OP_IDLE, 0, 1'b0);
    hi_l = 11'h13C; hi_r = 11'h7FF;
    rd_both("R2 same token other hi bits", 1, 1'b0, 1'b1);
    rd_both("R2 neighbour untouched", 0, 1'b1, 1'b1);
    hi_l = '0; hi_r = '0;
    // R3: only data bit 0 matters
    dhi_l = '1;
    cyc("R3 req with hi ones", OP_WR, 7, 1'b0, OP_IDLE, 0, 1'b0);
    rd_both("R3 granted", 7, 1'b0, 1'b1);
    dhi_l = '0;
    cyc("R3 release with hi zeros", OP_WR, 7, 1'b1, OP_IDLE, 0, 1'b0);
    rd_both("R3 released", 7, 1'b1, 1'b1);
    // R11: read captures pre-edge state
    cyc("R11 right owns", OP_IDLE, 0, 1'b0, OP_WR, 4, 1'b0);
    cyc("R11 left pending", OP_WR, 4, 1'b0, OP_IDLE, 0, 1'b0);
    cyc("R11 read during release", OP_RD, 4, 1'b0, OP_WR, 4, 1'b1);
    chk("R11 captured before handover", got_l, '1);
    rd_both("R11 afterwards", 4, 1'b0, 1'b1);

    // sweep: random mix over every token, compared with the model
    for (int n = 0; n < 4000; n++) begin
      hi_l = ADDR_W'($urandom); hi_r = ADDR_W'($urandom);
      dhi_l = DATA_W'($urandom); dhi_r = DATA_W'($urandom);
      cyc("R4-R9 sweep", $urandom_range(0, 2), $urandom_range(0, NUM - 1), 1'($urandom),
          $urandom_range(0, 2), $urandom_range(0, NUM - 1), 1'($urandom));
    end

    do_reset();
    hi_l = '0; hi_r = '0;
    for (int i = 0; i < NUM; i++) rd_both("R1 free after second reset", i, 1'b1, 1'b1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule